// File: doc/BRIEF.md
# Simple Operand Address Generator

This block turns a decoded addressing-mode request into a 32-bit operand address for the simple addressing modes of a CISC core. It covers plain register indirect, post-increment, pre-decrement, register plus 16-bit offset, short and long absolute, and program-counter plus 16-bit offset. The caller supplies the mode, the address-register number, the operand size, the register file's read value for that register, the PC, and the extension words already fetched. The block returns the address and, for the two auto-modify modes, a write-back of the updated register.

A request is sampled on the rising edge where `req` is high. The results appear on the registered outputs after that edge and stay there for one cycle. `addr` keeps its last value until the next accepted request. The write-back register number and data keep their values until the next auto-modify request. When a byte-sized operand uses register 7, the stack pointer, the auto-modify step is widened to two so that the stack stays word aligned.

Top module: `ag_simple_agen`

## Requirements
- R1: While `rst_n` is low, `addr_valid` and `wb_en` are 0 and `addr`, `wb_reg` and `wb_data` are all zero.
- R2: Mode 0 (register indirect) gives `addr` = `areg_val` one cycle after the request and does not assert `wb_en`.
- R3: Mode 1 (post-increment) gives `addr` = `areg_val` and writes back `areg_val` + step, with `wb_reg` = `reg_sel`. The step is 1, 2 or 4 for `op_size` codes 0, 1 and 2 (code 3 behaves as 4).
- R4: Mode 2 (pre-decrement) gives `addr` = `areg_val` − step, and writes back that same value, with `wb_reg` = `reg_sel`.
- R5: With `reg_sel` = 7 and `op_size` = 0, the post-increment and pre-decrement step is 2. For every other register a byte step stays 1.
- R6: Mode 3 gives `addr` = `areg_val` + sign-extended `ext_hi`.
- R7: Mode 4 gives `addr` = sign-extended `ext_hi`. Mode 5 gives `addr` = {`ext_hi`, `ext_lo`}.
- R8: Mode 6 gives `addr` = `pc_val` + sign-extended `ext_hi`. `pc_val` is the address of that offset word.
- R9: All sums and differences wrap modulo 2^32.
- R10: `wb_en` is high for exactly one cycle for each accepted request in mode 1 or 2, and never for any other mode.
- R11: Mode 7 is reserved. It raises neither `addr_valid` nor `wb_en`, and `addr` keeps its previous value.
- R12: In a cycle after an edge where `req` was low, `addr_valid` and `wb_en` are 0, and `addr`, `wb_reg` and `wb_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, sampled on the rising edge |
| mode | input | 3 | Addressing mode code 0..7 |
| reg_sel | input | 3 | Address-register number |
| op_size | input | 2 | Operand size code: 0 byte, 1 word, 2 long |
| areg_val | input | 32 | Read value of the selected address register |
| pc_val | input | 32 | Address of the offset extension word |
| ext_hi | input | 16 | First extension word |
| ext_lo | input | 16 | Second extension word (low half of a long absolute) |
| addr_valid | output | 1 | Address output is fresh this cycle |
| addr | output | 32 | Operand address |
| wb_en | output | 1 | Address-register write-back strobe |
| wb_reg | output | 3 | Register number to write back |
| wb_data | output | 32 | Updated register value |

## Verification
Every result register is loaded only on an accepted request, so an internal fault shows at the ports in the cycle right after the request that causes it. A wrong step shows as a `wb_data` that is off by one or two. A missed stack-pointer correction shows as an odd write-back. A stale hold shows as an `addr` that changes during idle cycles. The reference model follows each output on every cycle. Directed cases force the stack-pointer byte step and wrap-around at both ends of the address space, and the reserved mode.

// File: rtl/ag_pkg.sv
package ag_pkg;
  typedef enum logic [2:0] {
    AM_IND  = 3'd0,
    AM_POST = 3'd1,
    AM_PRE  = 3'd2,
    AM_DISP = 3'd3,
    AM_ABSW = 3'd4,
    AM_ABSL = 3'd5,
    AM_PCD  = 3'd6,
    AM_RSV  = 3'd7
  } am_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_L = 2'd2,
    SZ_X = 2'd3
  } sz_e;
endpackage

// File: rtl/ag_step.sv
// Auto-modify step: operand size in bytes, widened for byte stack access.
module ag_step #(
  parameter int AW     = 32,
  parameter int RW     = 3,
  parameter int SP_IDX = 7
) (
  input  logic [RW-1:0] reg_sel,
  input  logic [1:0]    op_size,
  output logic [AW-1:0] step
);
  import ag_pkg::*;
  localparam logic [RW-1:0] SP_SEL = RW'(SP_IDX);

  sz_e sz;
  assign sz = sz_e'(op_size);

  always_comb begin
    case (sz)
      SZ_B:    step = (reg_sel == SP_SEL) ? AW'(2) : AW'(1);
      SZ_W:    step = AW'(2);
      default: step = AW'(4);
    endcase
  end
endmodule

// File: rtl/ag_calc.sv
// Combinational address and write-back value selection.
module ag_calc #(
  parameter int AW = 32,
  parameter int EW = 16
) (
  input  logic [2:0]    mode,
  input  logic [AW-1:0] areg_val,
  input  logic [AW-1:0] pc_val,
  input  logic [EW-1:0] ext_hi,
  input  logic [EW-1:0] ext_lo,
  input  logic [AW-1:0] step,
  output logic [AW-1:0] addr_n,
  output logic [AW-1:0] wbd_n,
  output logic          wb_hit,
  output logic          ok
);
  import ag_pkg::*;
  localparam int XW = AW - EW;

  logic [AW-1:0] sext, inc, dec;
  am_e m;

  assign m    = am_e'(mode);
  assign sext = {{XW{ext_hi[EW-1]}}, ext_hi};
  assign inc  = areg_val + step;
  assign dec  = areg_val - step;

  always_comb begin
    addr_n = '0;
    wbd_n  = inc;
    wb_hit = 1'b0;
    ok     = 1'b1;
    case (m)
      AM_IND:  addr_n = areg_val;
      AM_POST: begin addr_n = areg_val; wbd_n = inc; wb_hit = 1'b1; end
      AM_PRE:  begin addr_n = dec;      wbd_n = dec; wb_hit = 1'b1; end
      AM_DISP: addr_n = areg_val + sext;
      AM_ABSW: addr_n = sext;
      AM_ABSL: addr_n = AW'({ext_hi, ext_lo});
      AM_PCD:  addr_n = pc_val + sext;
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/ag_simple_agen.sv
module ag_simple_agen #(
  parameter int AW     = 32,
  parameter int EW     = 16,
  parameter int RW     = 3,
  parameter int SP_IDX = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [2:0]    mode,
  input  logic [RW-1:0] reg_sel,
  input  logic [1:0]    op_size,
  input  logic [AW-1:0] areg_val,
  input  logic [AW-1:0] pc_val,
  input  logic [EW-1:0] ext_hi,
  input  logic [EW-1:0] ext_lo,
  output logic          addr_valid,
  output logic [AW-1:0] addr,
  output logic          wb_en,
  output logic [RW-1:0] wb_reg,
  output logic [AW-1:0] wb_data
);
  logic [AW-1:0] step, addr_n, wbd_n;
  logic          wb_hit, ok;

  ag_step #(.AW(AW), .RW(RW), .SP_IDX(SP_IDX)) u_step (
    .reg_sel (reg_sel),
    .op_size (op_size),
    .step    (step)
  );

  ag_calc #(.AW(AW), .EW(EW)) u_calc (
    .mode     (mode),
    .areg_val (areg_val),
    .pc_val   (pc_val),
    .ext_hi   (ext_hi),
    .ext_lo   (ext_lo),
    .step     (step),
    .addr_n   (addr_n),
    .wbd_n    (wbd_n),
    .wb_hit   (wb_hit),
    .ok       (ok)
  );

  logic          addr_ce, wb_ce;
  logic          valid_d, wben_d;
  logic [AW-1:0] addr_d, wbd_d;
  logic [RW-1:0] wbr_d;

  always_comb begin
    addr_ce = req & ok;
    wb_ce   = req & wb_hit;
    valid_d = addr_ce;
    wben_d  = wb_ce;
    addr_d  = addr_ce ? addr_n  : addr;
    wbd_d   = wb_ce   ? wbd_n   : wb_data;
    wbr_d   = wb_ce   ? reg_sel : wb_reg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      wb_en      <= 1'b0;
      addr       <= '0;
      wb_data    <= '0;
      wb_reg     <= '0;
    end else begin
      addr_valid <= valid_d;
      wb_en      <= wben_d;
      addr       <= addr_d;
      wb_data    <= wbd_d;
      wb_reg     <= wbr_d;
    end
  end
endmodule

// File: rtl/ag_chk.sv
module ag_chk #(
  parameter int AW = 32,
  parameter int EW = 16,
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic [2:0]    mode,
  input logic [RW-1:0] reg_sel,
  input logic [AW-1:0] areg_val,
  input logic          addr_valid,
  input logic [AW-1:0] addr,
  input logic          wb_en,
  input logic [RW-1:0] wb_reg,
  input logic [AW-1:0] wb_data
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R2
  ind_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(req && mode == 3'd0) |-> addr == $past(areg_val) && !wb_en);

  // R3
  post_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(req && mode == 3'd1) |-> addr == $past(areg_val) &&
      wb_reg == $past(reg_sel) && (wb_data - addr) inside {AW'(1), AW'(2), AW'(4)});

  // R4
  pre_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(req && mode == 3'd2) |-> wb_data == addr &&
      (($past(areg_val) - addr) inside {AW'(1), AW'(2), AW'(4)}));

  // R7
  absw_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(req && mode == 3'd4) |-> addr[AW-1:EW-1] == {(AW-EW+1){addr[EW-1]}});

  // R10
  wb_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen && wb_en |-> $past(req) && ($past(mode) inside {3'd1, 3'd2}) && addr_valid);

  // R11
  rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(req && mode == 3'd7) |-> !addr_valid && !wb_en && $stable(addr));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$past(req) |-> !addr_valid && !wb_en && $stable(addr) &&
      $stable(wb_data) && $stable(wb_reg));
endmodule

bind ag_simple_agen ag_chk #(.AW(AW), .EW(EW), .RW(RW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .mode       (mode),
  .reg_sel    (reg_sel),
  .areg_val   (areg_val),
  .addr_valid (addr_valid),
  .addr       (addr),
  .wb_en      (wb_en),
  .wb_reg     (wb_reg),
  .wb_data    (wb_data)
);

// File: tb/ag_simple_agen_test.sv
module ag_simple_agen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  mode = '0;
  logic [2:0]  reg_sel = '0;
  logic [1:0]  op_size = '0;
  logic [31:0] areg_val = '0, pc_val = '0;
  logic [15:0] ext_hi = '0, ext_lo = '0;
  logic        addr_valid, wb_en;
  logic [31:0] addr, wb_data;
  logic [2:0]  wb_reg;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  // model state
  bit          m_valid, m_wben;
  logic [31:0] m_addr, m_wbd;
  logic [2:0]  m_wbr;

  ag_simple_agen uut (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .reg_sel(reg_sel),
    .op_size(op_size), .areg_val(areg_val), .pc_val(pc_val), .ext_hi(ext_hi),
    .ext_lo(ext_lo), .addr_valid(addr_valid), .addr(addr), .wb_en(wb_en),
    .wb_reg(wb_reg), .wb_data(wb_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(bit r, int md, int rs, int sz);
    if (!r) return "R12";
    case (md)
      0: return "R2";
      1: return (rs == 7 && sz == 0) ? "R5" : "R3";
      2: return (rs == 7 && sz == 0) ? "R5" : "R4";
      3: return "R6";
      4, 5: return "R7";
      6: return "R8";
      default: return "R11";
    endcase
  endfunction

  // Called at a negedge: drive, predict, wait one cycle, compare.
  task automatic step_once(string tag, bit r, int md, int rs, int sz,
                           logic [31:0] a, logic [31:0] p,
                           logic [15:0] eh, logic [15:0] el);
    longint unsigned mask = 64'hFFFF_FFFF;
    longint unsigned s, off;
    req = r; mode = 3'(md); reg_sel = 3'(rs); op_size = 2'(sz);
    areg_val = a; pc_val = p; ext_hi = eh; ext_lo = el;
    s = (sz == 0) ? ((rs == 7) ? 2 : 1) : (sz == 1) ? 2 : 4;
    off = eh[15] ? (64'hFFFF_0000 | longint'(eh)) : longint'(eh);
    m_valid = 1'b0; m_wben = 1'b0;
    if (r) begin
      case (md)
        0: begin m_valid = 1; m_addr = a; end
        1: begin m_valid = 1; m_wben = 1; m_addr = a; m_wbd = 32'((longint'(a) + s) & mask); m_wbr = 3'(rs); end
        2: begin m_valid = 1; m_wben = 1; m_addr = 32'((longint'(a) + mask + 1 - s) & mask); m_wbd = m_addr; m_wbr = 3'(rs); end
        3: begin m_valid = 1; m_addr = 32'((longint'(a) + off) & mask); end
        4: begin m_valid = 1; m_addr = 32'(off); end
        5: begin m_valid = 1; m_addr = {eh, el}; end
        6: begin m_valid = 1; m_addr = 32'((longint'(p) + off) & mask); end
        default: ;
      endcase
    end
    @(negedge clk);
    chk(tag, "addr_valid", 32'(addr_valid), 32'(m_valid));
    chk(r && (md == 1 || md == 2) ? "R10" : tag, "wb_en", 32'(wb_en), 32'(m_wben));
    chk(tag, "addr", addr, m_addr);
    chk(tag, "wb_data", wb_data, m_wbd);
    chk(tag, "wb_reg", 32'(wb_reg), 32'(m_wbr));
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    // R1 reset state
    chk("R1", "addr_valid", 32'(addr_valid), 0);
    chk("R1", "wb_en", 32'(wb_en), 0);
    chk("R1", "addr", addr, 0);
    chk("R1", "wb_data", wb_data, 0);
    chk("R1", "wb_reg", 32'(wb_reg), 0);
    m_valid = 0; m_wben = 0; m_addr = 0; m_wbd = 0; m_wbr = 0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    step_once("R2", 1, 0, 3, 2, 32'h1234_5678, 0, 0, 0);
    step_once("R3", 1, 1, 2, 0, 32'h0000_1000, 0, 0, 0);
    step_once("R3", 1, 1, 4, 1, 32'h0000_2000, 0, 0, 0);
    step_once("R3", 1, 1, 5, 2, 32'h0000_3000, 0, 0, 0);
    step_once("R4", 1, 2, 1, 2, 32'h0000_4000, 0, 0, 0);
    step_once("R4", 1, 2, 6, 0, 32'h0000_4001, 0, 0, 0);
    step_once("R5", 1, 1, 7, 0, 32'h0000_8000, 0, 0, 0);
    step_once("R5", 1, 2, 7, 0, 32'h0000_8000, 0, 0, 0);
    step_once("R5", 1, 2, 7, 1, 32'h0000_8000, 0, 0, 0);
    step_once("R6", 1, 3, 0, 2, 32'h0001_0000, 0, 16'h8000, 0);
    step_once("R6", 1, 3, 0, 2, 32'h0001_0000, 0, 16'h7FFF, 0);
    step_once("R7", 1, 4, 0, 2, 0, 0, 16'hFFFE, 0);
    step_once("R7", 1, 4, 0, 2, 0, 0, 16'h1234, 0);
    step_once("R7", 1, 5, 0, 2, 0, 0, 16'hDEAD, 16'hBEEF);
    step_once("R8", 1, 6, 0, 2, 0, 32'h0000_0100, 16'hFF00, 0);
    step_once("R9", 1, 1, 3, 2, 32'hFFFF_FFFE, 0, 0, 0);
    step_once("R9", 1, 2, 3, 2, 32'h0000_0002, 0, 0, 0);
    step_once("R9", 1, 6, 0, 2, 32'h0, 32'hFFFF_FFF0, 16'h0020, 0);
    step_once("R9", 1, 3, 0, 2, 32'h0000_0004, 0, 16'hFFF0, 0);
    step_once("R11", 1, 7, 2, 2, 32'hAAAA_AAAA, 0, 16'h5555, 0);
    step_once("R12", 0, 1, 1, 2, 32'h5555_5555, 0, 0, 0);
    step_once("R12", 0, 2, 7, 0, 32'h7777_7777, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      int md = $urandom_range(0, 7);
      int rs = $urandom_range(0, 7);
      int sz = $urandom_range(0, 3);
      bit r  = ($urandom_range(0, 3) != 0);
      step_once(tag_of(r, md, rs, sz), r, md, rs, sz, $urandom, $urandom,
                16'($urandom), 16'($urandom));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule